// File: doc/BRIEF.md
# Prioritized CPU Exception Arbiter

This block sits between a processor core and the things that can interrupt it. It keeps a nine-bit register of pending hardware exception sources. Each source has its own level-style update strobe, and an upstream interrupt controller delivers numbered events that are translated into source bits. Whenever the core says it can accept an exception, the block picks one pending source by fixed priority. The choice honours a machine-check enable (ME) and an external enable (EE). The block then issues a one-cycle take strobe with a 4-bit exception code, and clears the bit it took.

The priority has tiers. A reset/critical input is taken regardless of masks. A machine check needs ME. The timer and external sources need EE and are scanned in a fixed inner order, with external last. The block also drives an aggregate request line, which is high while any bit is pending. It drives a wake signal for a halted core, and a one-cycle system-reset request for the controller's core-reset event.

Top module: `exc_arbiter`

## Requirements
- R1: Pending bit indices are: 0 reset/critical, 1 machine check, 2 external, 3 decrementer, 4 hypervisor decrementer, 5 programmable interval timer, 6 fixed interval timer, 7 watchdog, 8 debug. A synchronous reset clears all of them, so req_o, take_o and sysrst_req_o read 0 after reset.
- R2: In a cycle where src_upd_i[k] is 1, bit k is loaded from src_lvl_i[k]. A 1 sets the bit and raises req_o from the next cycle; a 0 clears it. req_o is low only when all nine bits are zero.
- R3: When accept_i is 1 and bit 0 is pending, bit 0 is taken with code 1, whatever me_i and ee_i are.
- R4: Otherwise a pending bit 1 is taken with code 2, but only when me_i is 1.
- R5: Otherwise, when ee_i is 1, sources are scanned in this order: bit 4 (code 3), bit 3 (code 4), bit 5 (code 5), bit 6 (code 6), bit 7 (code 7), bit 2 (code 8). The first pending one is taken.
- R6: Each cycle with accept_i high takes at most one exception. take_o pulses in the following cycle with the code on take_code_o and err_code_o at zero, and the taken bit is cleared at that same edge. With accept_i low, nothing is taken and pending bits are held.
- R7: After a take, req_o stays high while any other bit remains pending.
- R8: Controller events, sampled when ctl_evt_upd_i is 1, load the level into a source bit: code 0 loads bit 2, 1 loads bit 0, 2 loads bit 1, 3 loads bit 8. Code 4 with level 1 pulses sysrst_req_o for one cycle in the next cycle and changes no pending bit.
- R9: wake_o is 1 exactly when halted_i, ee_i and req_o are all 1.
- R10: Bit 8 (debug) is never taken and stays pending until it is loaded with 0.
- R11: With parameter HDEC_EN = 0, bit 4 is never taken.
- R12: If a source update sets the same bit that is being taken in that cycle, the set wins and the bit stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_upd_i | input | 9 | Per-source update strobe |
| src_lvl_i | input | 9 | Per-source level loaded on update |
| ctl_evt_upd_i | input | 1 | Controller event strobe |
| ctl_evt_code_i | input | 3 | Controller event number |
| ctl_evt_lvl_i | input | 1 | Controller event level |
| me_i | input | 1 | Machine-check enable |
| ee_i | input | 1 | External/timer enable |
| accept_i | input | 1 | Core can accept an exception this cycle |
| halted_i | input | 1 | Core is halted |
| take_o | output | 1 | One-cycle take strobe |
| take_code_o | output | 4 | Code of the taken exception |
| err_code_o | output | 8 | Error code, zero on take |
| req_o | output | 1 | Aggregate pending request |
| wake_o | output | 1 | Wake request for a halted core |
| sysrst_req_o | output | 1 | One-cycle system-reset request |

## Verification
A take and a new set can land on the same source bit in one cycle. The bench provokes this by holding a single decrementer bit pending and then raising accept together with a decrementer update at level 1. It then expects a take with code 4, req_o still high afterwards, and a second take with the same code on the next accept. Around this, every one of the 512 pending patterns is swept under all four ME/EE settings. The sweep runs on instances built with and without the hypervisor tier, and the code and remaining request are compared against an arithmetic model.

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter bit HDEC_EN = 1'b1,
  parameter int CODE_W  = 4,
  parameter int ERR_W   = 8,
  parameter int EVT_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [8:0]        src_upd_i,
  input  logic [8:0]        src_lvl_i,
  input  logic              ctl_evt_upd_i,
  input  logic [EVT_W-1:0]  ctl_evt_code_i,
  input  logic              ctl_evt_lvl_i,
  input  logic              me_i,
  input  logic              ee_i,
  input  logic              accept_i,
  input  logic              halted_i,
  output logic              take_o,
  output logic [CODE_W-1:0] take_code_o,
  output logic [ERR_W-1:0]  err_code_o,
  output logic              req_o,
  output logic              wake_o,
  output logic              sysrst_req_o
);
  localparam int NSRC  = 9;
  localparam int IDX_W = $clog2(NSRC);

  logic [NSRC-1:0]   pend, pend_nxt;
  logic              sel_hit;
  logic [IDX_W-1:0]  sel_idx;
  logic [CODE_W-1:0] sel_code;
  logic              evt_hit, evt_rst;
  logic [IDX_W-1:0]  evt_idx;

  always_comb begin
    sel_hit  = 1'b1;
    sel_idx  = '0;
    sel_code = '0;
    if (pend[0]) begin
      sel_idx = IDX_W'(0); sel_code = CODE_W'(1);
    end else if (me_i && pend[1]) begin
      sel_idx = IDX_W'(1); sel_code = CODE_W'(2);
    end else if (ee_i && HDEC_EN && pend[4]) begin
      sel_idx = IDX_W'(4); sel_code = CODE_W'(3);
    end else if (ee_i && pend[3]) begin
      sel_idx = IDX_W'(3); sel_code = CODE_W'(4);
    end else if (ee_i && pend[5]) begin
      sel_idx = IDX_W'(5); sel_code = CODE_W'(5);
    end else if (ee_i && pend[6]) begin
      sel_idx = IDX_W'(6); sel_code = CODE_W'(6);
    end else if (ee_i && pend[7]) begin
      sel_idx = IDX_W'(7); sel_code = CODE_W'(7);
    end else if (ee_i && pend[2]) begin
      sel_idx = IDX_W'(2); sel_code = CODE_W'(8);
    end else begin
      sel_hit = 1'b0;
    end
  end

  always_comb begin
    evt_hit = 1'b1;
    evt_rst = 1'b0;
    evt_idx = '0;
    case (ctl_evt_code_i)
      EVT_W'(0): evt_idx = IDX_W'(2);
      EVT_W'(1): evt_idx = IDX_W'(0);
      EVT_W'(2): evt_idx = IDX_W'(1);
      EVT_W'(3): evt_idx = IDX_W'(8);
      EVT_W'(4): begin evt_hit = 1'b0; evt_rst = 1'b1; end
      default:   evt_hit = 1'b0;
    endcase
  end

  always_comb begin
    pend_nxt = pend;
    if (accept_i && sel_hit) pend_nxt[sel_idx] = 1'b0;
    for (int k = 0; k < NSRC; k++)
      if (src_upd_i[k]) pend_nxt[k] = src_lvl_i[k];
    if (ctl_evt_upd_i && evt_hit) pend_nxt[evt_idx] = ctl_evt_lvl_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend         <= '0;
      take_o       <= 1'b0;
      take_code_o  <= '0;
      sysrst_req_o <= 1'b0;
    end else begin
      pend         <= pend_nxt;
      take_o       <= accept_i && sel_hit;
      take_code_o  <= (accept_i && sel_hit) ? sel_code : '0;
      sysrst_req_o <= ctl_evt_upd_i && evt_rst && ctl_evt_lvl_i;
    end
  end

  assign err_code_o = '0;
  assign req_o      = |pend;
  assign wake_o     = halted_i && ee_i && req_o;

  p_take_needs_accept_r6: assert property (@(posedge clk) disable iff (rst)
    take_o |-> $past(accept_i));
  p_reset_first_r3: assert property (@(posedge clk) disable iff (rst)
    (accept_i && pend[0]) |=> (take_o && take_code_o == CODE_W'(1)));
  p_mck_masked_r4: assert property (@(posedge clk) disable iff (rst)
    (take_o && take_code_o == CODE_W'(2)) |-> $past(me_i));
  p_ee_masked_r5: assert property (@(posedge clk) disable iff (rst)
    (take_o && take_code_o >= CODE_W'(3)) |-> $past(ee_i));
  p_set_raises_r2: assert property (@(posedge clk) disable iff (rst)
    ((|(src_upd_i & src_lvl_i)) && !ctl_evt_upd_i) |=> req_o);
  p_sysrst_src_r8: assert property (@(posedge clk) disable iff (rst)
    sysrst_req_o |-> $past(ctl_evt_upd_i && ctl_evt_lvl_i && ctl_evt_code_i == EVT_W'(4)));
  p_code_nonzero_r10: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (take_code_o != '0));
endmodule

// File: tb/tb_exc_arbiter.sv
`timescale 1ns/1ps
module tb_exc_arbiter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [8:0] src_upd = '0, src_lvl = '0;
  logic evt_upd = 1'b0, evt_lvl = 1'b0;
  logic [2:0] evt_code = '0;
  logic me = 1'b0, ee = 1'b0, acc = 1'b0, halted = 1'b0;
  logic take, take2, req, req2, wake, wake2, srst, srst2;
  logic [3:0] code, code2;
  logic [7:0] err, err2;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  exc_arbiter dut (.clk(clk), .rst(rst), .src_upd_i(src_upd), .src_lvl_i(src_lvl),
    .ctl_evt_upd_i(evt_upd), .ctl_evt_code_i(evt_code), .ctl_evt_lvl_i(evt_lvl),
    .me_i(me), .ee_i(ee), .accept_i(acc), .halted_i(halted), .take_o(take),
    .take_code_o(code), .err_code_o(err), .req_o(req), .wake_o(wake), .sysrst_req_o(srst));

  exc_arbiter #(.HDEC_EN(1'b0)) dut_nohd (.clk(clk), .rst(rst), .src_upd_i(src_upd),
    .src_lvl_i(src_lvl), .ctl_evt_upd_i(evt_upd), .ctl_evt_code_i(evt_code),
    .ctl_evt_lvl_i(evt_lvl), .me_i(me), .ee_i(ee), .accept_i(acc), .halted_i(halted),
    .take_o(take2), .take_code_o(code2), .err_code_o(err2), .req_o(req2), .wake_o(wake2),
    .sysrst_req_o(srst2));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_code(input int p, input bit m, input bit e, input bit hd);
    if (p[0]) return 1;
    if (m && p[1]) return 2;
    if (e) begin
      if (hd && p[4]) return 3;
      if (p[3]) return 4;
      if (p[5]) return 5;
      if (p[6]) return 6;
      if (p[7]) return 7;
      if (p[2]) return 8;
    end
    return 0;
  endfunction

  function automatic int code_bit(input int c);
    case (c)
      1: return 0; 2: return 1; 3: return 4; 4: return 3;
      8: return 2; default: return c;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; src_upd = '0; evt_upd = 1'b0; acc = 1'b0;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic load(input logic [8:0] mask, input logic [8:0] lvl);
    src_upd = mask; src_lvl = lvl;
    @(negedge clk); src_upd = '0;
  endtask

  task automatic accept_once();
    acc = 1'b1;
    @(negedge clk); acc = 1'b0;
  endtask

  task automatic event_in(input int c, input bit l);
    evt_upd = 1'b1; evt_code = 3'(c); evt_lvl = l;
    @(negedge clk); evt_upd = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    do_reset();
    chk(req == 0 && take == 0 && srst == 0, "R1 reset state", {req, take, srst}, 0);

    for (int p = 0; p < 512; p++)
      for (int mv = 0; mv < 2; mv++)
        for (int ev = 0; ev < 2; ev++) begin
          int e1, e2, r1, r2;
          do_reset();
          me = mv[0]; ee = ev[0];
          load(9'h1FF, 9'(p));
          chk(req == (p != 0), "R2 set raises req", req, p != 0);
          accept_once();
          e1 = exp_code(p, mv[0], ev[0], 1'b1);
          e2 = exp_code(p, mv[0], ev[0], 1'b0);
          r1 = (e1 == 0) ? p : (p & ~(1 << code_bit(e1)));
          r2 = (e2 == 0) ? p : (p & ~(1 << code_bit(e2)));
          chk(take == (e1 != 0), "R6 one take R3 R4 R5", take, e1 != 0);
          if (e1 != 0) chk(code == 4'(e1) && err == 0, "R3 R4 R5 code", code, e1);
          chk(req == (r1 != 0), "R7 req after take", req, r1 != 0);
          chk(take2 == (e2 != 0) && (e2 == 0 || code2 == 4'(e2)), "R11 no hdec code",
              code2, e2);
          chk(req2 == (r2 != 0), "R11 req after take", req2, r2 != 0);
        end

    do_reset(); me = 1; ee = 1;
    load(9'h008, 9'h008);
    load(9'h008, 9'h000);
    chk(req == 0, "R2 clear drops req", req, 0);
    accept_once();
    chk(take == 0, "R2 cleared bit not taken", take, 0);

    do_reset(); me = 1; ee = 1;
    load(9'h100, 9'h100);
    accept_once();
    chk(take == 0 && req == 1, "R10 debug never taken", take, 0);
    accept_once();
    chk(req == 1, "R10 debug stays pending", req, 1);
    load(9'h100, 9'h000);
    chk(req == 0, "R10 debug cleared by level", req, 0);

    do_reset(); me = 1; ee = 1;
    load(9'h004, 9'h004);
    acc = 1'b0; @(negedge clk); @(negedge clk);
    chk(take == 0 && req == 1, "R6 no accept holds pending", req, 1);

    for (int c = 0; c < 4; c++) begin
      int ex;
      ex = (c == 0) ? 8 : (c == 1) ? 1 : (c == 2) ? 2 : 0;
      do_reset(); me = 1; ee = 1;
      event_in(c, 1'b1);
      chk(req == 1, "R8 event sets bit", req, 1);
      accept_once();
      chk(take == (ex != 0) && (ex == 0 || code == 4'(ex)), "R8 event mapping", code, ex);
    end
    do_reset();
    event_in(1, 1'b1);
    event_in(1, 1'b0);
    chk(req == 0, "R8 event level 0 clears", req, 0);
    event_in(4, 1'b1);
    chk(srst == 1 && req == 0, "R8 core reset pulse", srst, 1);
    @(negedge clk);
    chk(srst == 0, "R8 core reset one cycle", srst, 0);

    for (int w = 0; w < 8; w++) begin
      do_reset();
      if (w[2]) load(9'h008, 9'h008);
      halted = w[0]; ee = w[1];
      #1;
      chk(wake == (w == 7), "R9 wake", wake, w == 7);
    end
    halted = 0;

    do_reset(); me = 1; ee = 1;
    load(9'h008, 9'h008);
    acc = 1'b1; src_upd = 9'h008; src_lvl = 9'h008;
    @(negedge clk); acc = 1'b0; src_upd = '0;
    chk(take == 1 && code == 4, "R12 take with same-cycle set", code, 4);
    chk(req == 1, "R12 set wins", req, 1);
    accept_once();
    chk(take == 1 && code == 4, "R12 retaken", code, 4);
    chk(req == 0, "R7 req drops when empty", req, 0);

    do_reset(); me = 1; ee = 1;
    load(9'h0FF, 9'h0FF);
    begin
      int order[8] = '{1, 2, 3, 4, 5, 6, 7, 8};
      acc = 1'b1;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        chk(take == 1 && code == 4'(order[i]), "R5 drain order", code, order[i]);
      end
      acc = 1'b0;
    end
    @(negedge clk);
    chk(req == 0 && take == 0, "R6 drained", req, 0);

    finish_run();
  end
endmodule